// File: doc/BRIEF.md
# FIFO Threshold Interrupt Generator

This block sits between the transmit and receive FIFOs of a serial port and its register block. Every cycle it receives the current fill level of each FIFO, together with the receive pop strobe and the transmit push strobe. It compares each level with a trigger count taken from a small level-select code. From these comparisons it keeps a set of raw interrupt status bits. A status bit is set by an event and then stays set until FIFO activity or a software clear removes it.

The receive interrupt fires when the receive FIFO fills up past its trigger. The transmit interrupt fires when the transmit FIFO drains down to its trigger. A receive-timeout bit shows whether receive data is waiting. Three modem-change bits record every change of the link state. When the FIFOs are turned off, the trigger counts are forced so that the port behaves as a single-entry holding register. The block also tells the transmit storage when a push reaches a full FIFO, so that the storage overwrites its newest entry and does not stall.

Top module: `fifo_thresh_irq`

## Requirements
- R1: With `fifo_en` high, level-select code 0, 1, 2, 3 or 4 gives a trigger of DEPTH/8, DEPTH/4, DEPTH/2, 3·DEPTH/4 or 7·DEPTH/8 entries. With DEPTH = 32 these are 4, 8, 16, 24 and 28. Codes 5, 6 and 7 give DEPTH/2.
- R2: With `fifo_en` low, the receive trigger is 1, the transmit trigger is 0 and each FIFO counts as one entry deep.
- R3: `status[0]` (receive) goes high one cycle after the receive level moves from below the trigger to at or above it, compared with the level of the previous cycle.
- R4: `status[0]` is cleared one cycle after a receive pop that leaves the receive level below the trigger.
- R5: `status[1]` (transmit) goes high one cycle after the transmit level moves from above the trigger to at or below it.
- R6: `status[1]` is cleared one cycle after a transmit push that leaves the transmit level above the trigger.
- R7: `status[2]` (receive timeout) equals, one cycle later, whether the receive level is non-zero. `status_clr[2]` has no effect on it.
- R8: Each change of `link_up`, rising or falling, sets `status[3]`, `status[4]` and `status[5]` one cycle later.
- R9: A high bit of `status_clr` clears the same status bit on the next edge. When a set event hits the same bit in the same cycle, the bit is set.
- R10: `tx_replace` is high in the same cycle as a transmit push made while the level of the previous cycle was at full depth.
- R11: Synchronous reset clears all status bits and the stored levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled; when low, the forced triggers apply |
| rx_level_sel | input | 3 | Receive trigger code |
| tx_level_sel | input | 3 | Transmit trigger code |
| rx_count | input | 6 | Receive FIFO level after this cycle's operation |
| tx_count | input | 6 | Transmit FIFO level after this cycle's operation |
| rx_pop | input | 1 | A receive entry is removed this cycle |
| tx_push | input | 1 | A transmit entry is written this cycle |
| link_up | input | 1 | Link state |
| status_clr | input | 6 | Per-bit software clear, same positions as `status` |
| status | output | 6 | Bit 0 receive, 1 transmit, 2 receive timeout, 3 CTS change, 4 DCD change, 5 DSR change |
| tx_replace | output | 1 | This push overwrites the newest stored transmit entry |

## Verification
The bench aims at the edges of each trigger window. It fills the receive FIFO to one below the trigger and then to the trigger, for every code including the three unused ones. A comparator off by one would fire one entry early or late, and a wrong default would fire at the wrong depth. Disabling the FIFOs checks the forced triggers of 1 and 0; a design that kept the coded trigger would never raise the transmit bit when the FIFO empties. A software clear in the same cycle as a crossing is aimed at the priority rule; a design in which the clear wins would lose the interrupt. Random traffic with link toggles and stray clears also tests that the receive-timeout bit ignores the clear and that both link directions set the change bits.

// File: rtl/fthr_pkg.sv
// Package: shared constants for the FIFO threshold interrupt generator.
// Assumes the status vector layout is fixed, because the register block decodes it.
package fthr_pkg;
    localparam int ST_W   = 6;
    localparam int ST_RX  = 0;
    localparam int ST_TX  = 1;
    localparam int ST_RTO = 2;
    localparam int ST_CTS = 3;
    localparam int ST_DCD = 4;
    localparam int ST_DSR = 5;

    typedef enum logic [2:0] {
        LVL_EIGHTH   = 3'd0,
        LVL_QUARTER  = 3'd1,
        LVL_HALF     = 3'd2,
        LVL_3QUARTER = 3'd3,
        LVL_7EIGHTH  = 3'd4
    } lvl_code_e;
endpackage

// File: rtl/fthr_trig_decode.sv
// Module: turns a 3-bit level code into a trigger count.
// Assumes DEPTH is a multiple of 8. When FIFOs are disabled, DIS_TRIG is forced.
module fthr_trig_decode #(
    parameter int DEPTH    = 32,
    parameter int CW       = $clog2(DEPTH + 1),
    parameter int DIS_TRIG = 1
) (
    input  logic          fifo_en,
    input  logic [2:0]    code,
    output logic [CW-1:0] trig
);
    import fthr_pkg::*;

    localparam logic [CW-1:0] T_EIGHTH = CW'(DEPTH / 8);
    localparam logic [CW-1:0] T_QUART  = CW'(DEPTH / 4);
    localparam logic [CW-1:0] T_HALF   = CW'(DEPTH / 2);
    localparam logic [CW-1:0] T_3Q     = CW'((3 * DEPTH) / 4);
    localparam logic [CW-1:0] T_7E     = CW'((7 * DEPTH) / 8);
    localparam logic [CW-1:0] T_DIS    = CW'(DIS_TRIG);

    // Select the trigger; unused codes fall back to half depth.
    always_comb begin
        if (!fifo_en) begin
            trig = T_DIS;
        end else begin
            case (code)
                LVL_EIGHTH:   trig = T_EIGHTH;
                LVL_QUARTER:  trig = T_QUART;
                LVL_HALF:     trig = T_HALF;
                LVL_3QUARTER: trig = T_3Q;
                LVL_7EIGHTH:  trig = T_7E;
                default:      trig = T_HALF;
            endcase
        end
    end
endmodule

// File: rtl/fthr_thr_watch.sv
// Module: watches one FIFO level for a threshold crossing and keeps its status bit.
// RISING=1: sets on an upward crossing and clears when a strobe leaves the level below trig.
// RISING=0: sets on a downward crossing and clears when a strobe leaves the level above trig.
// Assumes cnt is the level after this cycle's operation. A set beats any clear.
module fthr_thr_watch #(
    parameter int CW     = 6,
    parameter bit RISING = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] trig,
    input  logic          strobe,
    input  logic          sw_clr,
    output logic [CW-1:0] cnt_q,
    output logic          irq
);
    logic set_ev;
    logic hw_clr;

    generate
        if (RISING) begin : g_rise
            // Detect a fill past the trigger and a drain below it.
            always_comb begin
                set_ev = (cnt_q < trig) && (cnt >= trig);
                hw_clr = strobe && (cnt < trig);
            end

            // R3
            rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt_q < trig) && (cnt >= trig) |=> irq);
            // R4
            rx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                strobe && (cnt < trig) |=> !irq);
        end else begin : g_fall
            // Detect a drain to the trigger and a refill above it.
            always_comb begin
                set_ev = (cnt_q > trig) && (cnt <= trig);
                hw_clr = strobe && (cnt > trig);
            end

            // R5
            tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt_q > trig) && (cnt <= trig) |=> irq);
            // R6
            tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                strobe && (cnt > trig) |=> !irq);
        end
    endgenerate

    // Keep the previous level and the edge-set, level-cleared status bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            cnt_q <= cnt;
            irq   <= set_ev | (irq & ~hw_clr & ~sw_clr);
        end
    end
endmodule

// File: rtl/fthr_link_watch.sv
// Module: latches the three modem-change bits on any change of the link state.
// Assumes link_up is synchronous to clk. Reset samples the link so that no change appears at start-up.
module fthr_link_watch #(
    parameter int NCHG = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            link_up,
    input  logic [NCHG-1:0] sw_clr,
    output logic [NCHG-1:0] chg
);
    logic link_q;
    logic toggled;

    // Flag a change of link state in either direction.
    always_comb toggled = link_up ^ link_q;

    // Track the link and hold the change bits until they are cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q <= link_up;
            chg    <= '0;
        end else begin
            link_q <= link_up;
            chg    <= {NCHG{toggled}} | (chg & ~sw_clr);
        end
    end

    // R8
    link_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(link_up) |=> (chg == {NCHG{1'b1}}));
endmodule

// File: rtl/fifo_thresh_irq.sv
// Module: top of the FIFO threshold interrupt generator.
// Builds the raw status vector from the two FIFO levels, the trigger codes and the link state.
// Assumes the FIFO storage flushes both FIFOs when fifo_en falls.
module fifo_thresh_irq #(
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [2:0]    rx_level_sel,
    input  logic [2:0]    tx_level_sel,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          rx_pop,
    input  logic          tx_push,
    input  logic          link_up,
    input  logic [5:0]    status_clr,
    output logic [5:0]    status,
    output logic          tx_replace
);
    import fthr_pkg::*;

    localparam logic [CW-1:0] FULL_ON  = CW'(DEPTH);
    localparam logic [CW-1:0] FULL_OFF = CW'(1);

    logic [CW-1:0] rx_trig;
    logic [CW-1:0] tx_trig;
    logic [CW-1:0] rx_prev;
    logic [CW-1:0] tx_prev;
    logic [CW-1:0] full_lvl;
    logic          rx_irq;
    logic          tx_irq;
    logic          rto_q;
    logic [2:0]    modem_chg;

    fthr_trig_decode #(.DEPTH(DEPTH), .CW(CW), .DIS_TRIG(1)) i_rx_dec (
        .fifo_en (fifo_en),
        .code    (rx_level_sel),
        .trig    (rx_trig)
    );

    fthr_trig_decode #(.DEPTH(DEPTH), .CW(CW), .DIS_TRIG(0)) i_tx_dec (
        .fifo_en (fifo_en),
        .code    (tx_level_sel),
        .trig    (tx_trig)
    );

    fthr_thr_watch #(.CW(CW), .RISING(1'b1)) i_rx_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt    (rx_count),
        .trig   (rx_trig),
        .strobe (rx_pop),
        .sw_clr (status_clr[ST_RX]),
        .cnt_q  (rx_prev),
        .irq    (rx_irq)
    );

    fthr_thr_watch #(.CW(CW), .RISING(1'b0)) i_tx_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt    (tx_count),
        .trig   (tx_trig),
        .strobe (tx_push),
        .sw_clr (status_clr[ST_TX]),
        .cnt_q  (tx_prev),
        .irq    (tx_irq)
    );

    fthr_link_watch #(.NCHG(3)) i_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .sw_clr  (status_clr[ST_DSR:ST_CTS]),
        .chg     (modem_chg)
    );

    // Receive timeout follows receive occupancy and ignores software clears.
    always_ff @(posedge clk) begin
        if (!rst_n) rto_q <= 1'b0;
        else        rto_q <= (rx_count != '0);
    end

    // Effective depth, and the overwrite indication for a push into a full FIFO.
    always_comb begin
        full_lvl   = fifo_en ? FULL_ON : FULL_OFF;
        tx_replace = tx_push && (tx_prev >= full_lvl);
    end

    // Pack the status vector in the layout that the register block decodes.
    always_comb begin
        status                  = '0;
        status[ST_RX]           = rx_irq;
        status[ST_TX]           = tx_irq;
        status[ST_RTO]          = rto_q;
        status[ST_DSR:ST_CTS]   = modem_chg;
    end

    // R7
    rto_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[ST_RTO] == $past(rx_count != '0)));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (status == '0));
endmodule

// File: tb/test_fifo_thresh_irq.sv
module test_fifo_thresh_irq;
    localparam int DEPTH = 32;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_en;
    logic [2:0] rx_level_sel, tx_level_sel;
    logic [5:0] rx_count, tx_count;
    logic       rx_pop, tx_push, link_up;
    logic [5:0] status_clr;
    logic [5:0] status;
    logic       tx_replace;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model state
    int   rxc = 0, txc = 0;
    bit   en = 1, lnk = 0, lnkp = 0, flush = 0;
    int   rsel = 2, tsel = 2;
    logic [5:0] exp_st = '0;

    always #5 clk = ~clk;

    fifo_thresh_irq #(.DEPTH(DEPTH)) i_fifo_thresh_irq (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .rx_level_sel(rx_level_sel), .tx_level_sel(tx_level_sel),
        .rx_count(rx_count), .tx_count(tx_count),
        .rx_pop(rx_pop), .tx_push(tx_push), .link_up(link_up),
        .status_clr(status_clr), .status(status), .tx_replace(tx_replace)
    );

    function automatic int trig_of(input int code, input bit en_, input bit is_rx);
        if (!en_) return is_rx ? 1 : 0;
        case (code)
            0: return 4;
            1: return 8;
            2: return 16;
            3: return 24;
            4: return 28;
            default: return 16;
        endcase
    endfunction

    function automatic string tag_of(input int b);
        case (b)
            0: return "R3/R4";
            1: return "R5/R6";
            2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // One clock of stimulus; the model predicts the status that follows.
    task automatic step(input bit rpu, input bit rpo, input bit tpu, input bit tpo,
                        input logic [5:0] cv);
        int depth, rt, tt, rxp, txp, nrx, ntx;
        bit po_r, pu_t;
        logic [5:0] nx;
        @(negedge clk);
        depth = en ? DEPTH : 1;
        rxp = rxc; txp = txc;
        if (flush) begin rxc = 0; txc = 0; flush = 0; end
        nrx = rxc; ntx = txc; po_r = 0; pu_t = 0;
        if (rpu && !rpo && rxc < depth) nrx = rxc + 1;
        else if (rpo && !rpu && rxc > 0) begin nrx = rxc - 1; po_r = 1; end
        if (tpu && !tpo) begin pu_t = 1; if (txc < depth) ntx = txc + 1; end
        else if (tpo && !tpu && txc > 0) ntx = txc - 1;
        fifo_en = en; rx_level_sel = 3'(rsel); tx_level_sel = 3'(tsel);
        rx_count = 6'(nrx); tx_count = 6'(ntx);
        rx_pop = po_r; tx_push = pu_t; status_clr = cv; link_up = lnk;
        #1;
        chk("R10", int'(tx_replace), int'(pu_t && txp >= depth));
        rt = trig_of(rsel, en, 1); tt = trig_of(tsel, en, 0);
        nx = exp_st;
        nx[0] = (rxp < rt && nrx >= rt) | (exp_st[0] & !(po_r && nrx < rt) & !cv[0]);
        nx[1] = (txp > tt && ntx <= tt) | (exp_st[1] & !(pu_t && ntx > tt) & !cv[1]);
        nx[2] = (nrx != 0);
        for (int i = 3; i < 6; i++) nx[i] = (lnk != lnkp) | (exp_st[i] & !cv[i]);
        rxc = nrx; txc = ntx; lnkp = lnk; exp_st = nx;
        @(posedge clk); #1;
        for (int i = 0; i < 6; i++) chk(tag_of(i), int'(status[i]), int'(exp_st[i]));
    endtask

    task automatic drain_all();
        while (rxc > 0 || txc > 0) step(0, rxc > 0, 0, txc > 0, 6'h3f);
        step(0, 0, 0, 0, 6'h3f);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd20240517));
        rst_n = 0; fifo_en = 1; rx_level_sel = 3'd2; tx_level_sel = 3'd2;
        rx_count = 0; tx_count = 0; rx_pop = 0; tx_push = 0; link_up = 0; status_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        chk("R11", int'(status), 0);

        // R1: every code, including the unused ones
        for (int c = 0; c < 8; c++) begin
            int t;
            rsel = c; t = trig_of(c, 1, 1);
            drain_all();
            while (rxc < t - 1) step(1, 0, 0, 0, 0);
            chk("R1", int'(status[0]), 0);
            step(1, 0, 0, 0, 0);
            chk("R1", int'(status[0]), 1);
            step(0, 1, 0, 0, 0);
            chk("R4", int'(status[0]), 0);
        end
        drain_all();

        // R6: a push above the trigger clears the transmit bit
        tsel = 0;
        repeat (6) step(0, 0, 1, 0, 0);
        repeat (2) step(0, 0, 0, 1, 0);
        chk("R5", int'(status[1]), 1);
        step(0, 0, 1, 0, 0);
        chk("R6", int'(status[1]), 0);
        drain_all();

        // R9: a set in the same cycle as a clear wins; a clear alone removes the bit
        rsel = 0;
        repeat (3) step(1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 6'h01);
        chk("R9", int'(status[0]), 1);
        step(0, 0, 0, 0, 6'h01);
        chk("R9", int'(status[0]), 0);
        step(0, 0, 0, 0, 6'h04);
        chk("R7", int'(status[2]), 1);
        drain_all();

        // R8: both link directions
        lnk = 1; step(0, 0, 0, 0, 0);
        chk("R8", int'(status[5:3]), 7);
        step(0, 0, 0, 0, 6'h38);
        chk("R8", int'(status[5:3]), 0);
        lnk = 0; step(0, 0, 0, 0, 0);
        chk("R8", int'(status[5:3]), 7);

        // R2: forced triggers with FIFOs disabled
        en = 0; flush = 1; step(0, 0, 0, 0, 6'h3f);
        step(1, 0, 0, 0, 0);
        chk("R2", int'(status[0]), 1);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        chk("R10", int'(tx_replace), 1);
        step(0, 0, 0, 1, 0);
        chk("R2", int'(status[1]), 1);
        step(0, 1, 0, 0, 0);
        chk("R2", int'(status[0]), 0);
        en = 1; step(0, 0, 0, 0, 6'h3f);

        // random traffic with phased fill bias
        for (int n = 0; n < 6000; n++) begin
            bit fill;
            logic [5:0] cv;
            fill = ((n / 250) % 2) == 0;
            if ($urandom % 64 == 0) rsel = $urandom % 8;
            if ($urandom % 64 == 0) tsel = $urandom % 8;
            if ($urandom % 50 == 0) lnk = !lnk;
            if ($urandom % 400 == 0) begin
                if (en) flush = 1;
                en = !en;
            end
            cv = ($urandom % 8 == 0) ? 6'($urandom) : 6'h0;
            step(($urandom % 100) < (fill ? 65 : 30), ($urandom % 100) < (fill ? 30 : 65),
                 ($urandom % 100) < (fill ? 65 : 30), ($urandom % 100) < (fill ? 30 : 65), cv);
        end
        report();
    end
endmodule